// File: doc/BRIEF.md
# Receive FIFO with Character Timeout

This block is the receive half of a classic byte-oriented serial port. It sits between a byte-arrival interface and the register bus. Received bytes land either in one holding register or in a 16-deep first-in first-out store. The FIFO control byte written by the host selects which of the two is used. The block keeps the receive-side line flags (data ready, overrun, break) and gives the host a read port for received data. It also gives the interrupt logic two flags: one says the fill level has reached the selected trigger, and one says data has waited too long without being read.

A pulse on `rx_valid` or `rx_break` delivers one character from an external deserializer. A break is stored as a zero byte. The host reads data by pulsing `rbr_rd` and takes `rd_data` in that same cycle. It reads the line flags by pulsing `lsr_rd`, and writes the FIFO control byte with `fcr_wr`. The character timeout is measured in clock cycles, using the divisor and the frame-format bits given as inputs.

Top module: `uart_rx_fifo`

## Requirements
- R1: After synchronous reset, `fifo_level`, `data_ready`, `overrun`, `break_flag`, `timeout_pending`, `tx_flush` and `fcr_value` are all 0. Bit 0 of the FIFO control byte is the FIFO enable, so the block starts in single-register mode, and `rd_data` reads 0.
- R2: A write to the FIFO control byte keeps only the bits in mask 0xC9, and `fcr_value` shows them from the next cycle. Bits 7:6 select the trigger level: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. With the FIFO enabled, `trigger_hit` is 1 exactly when `fifo_level` is greater than or equal to that level.
- R3: With the FIFO disabled, `trigger_hit` follows `data_ready`.
- R4: With the FIFO enabled, bytes are read back in arrival order, one per `rbr_rd` pulse. A read of an empty FIFO returns 0. A read that leaves the FIFO empty clears `data_ready` and `break_flag`.
- R5: With the FIFO enabled, a byte that arrives when 16 bytes are stored and no read is made in that cycle is dropped, `overrun` is set, and `fifo_level` stays at 16.
- R6: With the FIFO disabled, a byte that arrives while `data_ready` is 1 and no read is made in that cycle overwrites the holding register and sets `overrun`.
- R7: A break event stores a zero byte and sets both `break_flag` and `data_ready`.
- R8: An `lsr_rd` pulse clears `overrun` and `break_flag` and leaves `data_ready` unchanged. An event that sets a flag in the same cycle takes priority over the clear.
- R9: Writing the control byte with bit 1 set empties the receive FIFO and clears `data_ready`, `break_flag` and `timeout_pending`.
- R10: A control write that changes bit 0 empties the receive FIFO. That write, or any control write with bit 2 set, raises `tx_flush` for exactly one cycle, starting the cycle after the write.
- R11: With the FIFO enabled and non-empty, `timeout_pending` rises 4×T cycles after the last arrival or read. T = max(divisor,1) × 16 × frame bits. Frame bits = 1 + (frame_fmt[1:0]+5) + frame_fmt[3] + (frame_fmt[2] ? 2 : 1). Any arrival or read clears `timeout_pending` and restarts the count. In single-register mode the flag never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One received character is offered this cycle |
| rx_data | input | 8 | Received character |
| rx_break | input | 1 | A break condition was received this cycle |
| rbr_rd | input | 1 | Host reads the receive data port this cycle |
| rd_data | output | 8 | Data returned to a receive read |
| lsr_rd | input | 1 | Host reads the line flags this cycle |
| fcr_wr | input | 1 | Host writes the FIFO control byte |
| fcr_wdata | input | 8 | FIFO control byte value |
| divisor | input | DIV_W | Baud divisor, 0 treated as 1 |
| frame_fmt | input | 4 | Frame format: [1:0] data length, [2] long stop, [3] parity |
| data_ready | output | 1 | Received data available |
| overrun | output | 1 | A character was lost |
| break_flag | output | 1 | A break was received |
| timeout_pending | output | 1 | Character timeout reached |
| trigger_hit | output | 1 | Fill level at or above trigger (FIFO mode) or data ready |
| fifo_level | output | CW | Bytes stored in the receive FIFO |
| fcr_value | output | 8 | Retained FIFO control bits |
| tx_flush | output | 1 | One-cycle request to empty the transmit FIFO |

## Verification
Bad pointer or count state shows on the very next `rbr_rd`: `rd_data` returns the wrong byte, or `fifo_level` drifts away from the number of pushes minus pops. A flag register that is out of step shows up within one cycle as a `data_ready`, `overrun` or `break_flag` value that does not match the last arrival, read or flush. A timeout counter with the wrong limit or a missed restart moves the rising edge of `timeout_pending` by whole cycles. The bench therefore samples that flag in the cycle just before and just after the predicted edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    // Receive-side line flags
    typedef struct packed {
        logic dr;   // data ready
        logic oe;   // overrun
        logic bi;   // break
    } rx_flags_t;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_sel_e;

    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;
    localparam int         TMO_CHARS     = 4;

    function automatic logic [7:0] trig_level(input logic [1:0] sel);
        case (trig_sel_e'(sel))
            TRIG_ONE:      return 8'd1;
            TRIG_FOUR:     return 8'd4;
            TRIG_EIGHT:    return 8'd8;
            default:       return 8'd14;
        endcase
    endfunction

    // start + data + optional parity + stop(s)
    function automatic logic [31:0] frame_bits(input logic [3:0] fmt);
        logic [31:0] n;
        n = 32'd1 + 32'(fmt[1:0]) + 32'd5 + 32'(fmt[3]);
        n = n + (fmt[2] ? 32'd2 : 32'd1);
        return n;
    endfunction

    function automatic logic [31:0] char_cycles(input logic [31:0] div,
                                                input logic [3:0]  fmt,
                                                input logic [31:0] os);
        logic [31:0] d;
        d = (div == 32'd0) ? 32'd1 : div;
        return d * os * frame_bits(fmt);
    endfunction

endpackage

// File: rtl/rx_store.sv
module rx_store #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign level = cnt_q;
endmodule

// File: rtl/rx_timeout.sv
module rx_timeout #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          pending
);
    logic [TW-1:0] cnt_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
        end else if (!pend_q) begin
            if (cnt_q >= limit - 1'b1) begin
                cnt_q  <= '0;
                pend_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter  int DEPTH      = 16,
    parameter  int DIV_W      = 16,
    parameter  int OVERSAMPLE = 16,
    localparam int CW         = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    input  logic             rx_break,
    input  logic             rbr_rd,
    output logic [7:0]       rd_data,
    input  logic             lsr_rd,
    input  logic             fcr_wr,
    input  logic [7:0]       fcr_wdata,
    input  logic [DIV_W-1:0] divisor,
    input  logic [3:0]       frame_fmt,
    output logic             data_ready,
    output logic             overrun,
    output logic             break_flag,
    output logic             timeout_pending,
    output logic             trigger_hit,
    output logic [CW-1:0]    fifo_level,
    output logic [7:0]       fcr_value,
    output logic             tx_flush
);
    logic [7:0]    fcr_q, hold_q, fcr_new, in_byte, head;
    rx_flags_t     flg_q, flg_d;
    logic          tx_flush_q;
    logic          fe, en_toggle, rx_flush, arrive;
    logic          full, empty, push, pop, read_clears, ovr_evt;
    logic [CW-1:0] level;
    logic [31:0]   tmo_limit;

    assign fe        = fcr_q[0];
    assign fcr_new   = fcr_wdata & FCR_KEEP_MASK;
    assign en_toggle = fcr_wr && (fcr_new[0] != fe);
    assign rx_flush  = fcr_wr && (en_toggle || fcr_wdata[1]);
    assign arrive    = rx_valid || rx_break;
    assign in_byte   = rx_break ? 8'h00 : rx_data;

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);
    assign pop   = fe && rbr_rd && !empty && !rx_flush;
    assign push  = fe && arrive && (!full || pop) && !rx_flush;

    assign ovr_evt     = fe ? (full && !pop) : (flg_q.dr && !rbr_rd);
    assign read_clears = rbr_rd && (!fe || level <= CW'(1));

    rx_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .push  (push),
        .pop   (pop),
        .din   (in_byte),
        .head  (head),
        .level (level)
    );

    assign tmo_limit = char_cycles(32'(divisor), frame_fmt, 32'(OVERSAMPLE))
                       * 32'(TMO_CHARS);

    rx_timeout #(.TW(32)) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .restart (arrive || rbr_rd || rx_flush),
        .run     (fe && !empty),
        .limit   (tmo_limit),
        .pending (timeout_pending)
    );

    always_comb begin
        flg_d = flg_q;
        if (read_clears) begin
            flg_d.dr = 1'b0;
            flg_d.bi = 1'b0;
        end
        if (lsr_rd) begin
            flg_d.oe = 1'b0;
            flg_d.bi = 1'b0;
        end
        if (rx_flush) begin
            flg_d.dr = 1'b0;
            flg_d.bi = 1'b0;
        end else if (arrive) begin
            flg_d.dr = 1'b1;
            if (rx_break) flg_d.bi = 1'b1;
            if (ovr_evt)  flg_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcr_q      <= '0;
            hold_q     <= '0;
            flg_q      <= '0;
            tx_flush_q <= 1'b0;
        end else begin
            flg_q      <= flg_d;
            tx_flush_q <= fcr_wr && (en_toggle || fcr_wdata[2]);
            if (fcr_wr) fcr_q <= fcr_new;
            if (!fe && arrive && !rx_flush) hold_q <= in_byte;
        end
    end

    assign rd_data     = fe ? (empty ? 8'h00 : head) : hold_q;
    assign trigger_hit = fe ? (level >= CW'(trig_level(fcr_q[7:6]))) : flg_q.dr;
    assign data_ready  = flg_q.dr;
    assign overrun     = flg_q.oe;
    assign break_flag  = flg_q.bi;
    assign fifo_level  = level;
    assign fcr_value   = fcr_q;
    assign tx_flush    = tx_flush_q;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
module uart_rx_fifo_chk #(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_valid,
    input logic          rx_break,
    input logic          rbr_rd,
    input logic          lsr_rd,
    input logic          fcr_wr,
    input logic [7:0]    fcr_wdata,
    input logic [CW-1:0] fifo_level,
    input logic          overrun,
    input logic          break_flag,
    input logic          data_ready,
    input logic          timeout_pending,
    input logic          trigger_hit,
    input logic [7:0]    fcr_value
);
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= CW'(DEPTH));

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
        (fcr_value[0] && fifo_level == CW'(DEPTH) && rx_valid && !rbr_rd && !fcr_wr)
        |=> (overrun && fifo_level == CW'(DEPTH)));

    assert_fcr_mask_R2: assert property (@(posedge clk) disable iff (rst)
        fcr_wr |=> (fcr_value == ($past(fcr_wdata) & 8'hC9)));

    assert_trig_top_R2: assert property (@(posedge clk) disable iff (rst)
        (fcr_value[0] && fifo_level >= CW'(14)) |-> trigger_hit);

    assert_break_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_break && !fcr_wr) |=> (break_flag && data_ready));

    assert_lsr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !rx_valid && !rx_break) |=> (!overrun && !break_flag));

    assert_tmo_data_R11: assert property (@(posedge clk) disable iff (rst)
        timeout_pending |-> (fifo_level != '0));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .rx_valid        (rx_valid),
    .rx_break        (rx_break),
    .rbr_rd          (rbr_rd),
    .lsr_rd          (lsr_rd),
    .fcr_wr          (fcr_wr),
    .fcr_wdata       (fcr_wdata),
    .fifo_level      (fifo_level),
    .overrun         (overrun),
    .break_flag      (break_flag),
    .data_ready      (data_ready),
    .timeout_pending (timeout_pending),
    .trigger_hit     (trigger_hit),
    .fcr_value       (fcr_value)
);

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
    logic        clk = 1'b0;
    logic        rst, rx_valid, rx_break, rbr_rd, lsr_rd, fcr_wr;
    logic [7:0]  rx_data, fcr_wdata, rd_data, fcr_value;
    logic [15:0] divisor;
    logic [3:0]  frame_fmt;
    logic        data_ready, overrun, break_flag, timeout_pending, trigger_hit, tx_flush;
    logic [4:0]  fifo_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    uart_rx_fifo uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rbr_rd(rbr_rd), .rd_data(rd_data),
        .lsr_rd(lsr_rd), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .divisor(divisor), .frame_fmt(frame_fmt), .data_ready(data_ready),
        .overrun(overrun), .break_flag(break_flag),
        .timeout_pending(timeout_pending), .trigger_hit(trigger_hit),
        .fifo_level(fifo_level), .fcr_value(fcr_value), .tx_flush(tx_flush)
    );

    // {control byte, bytes pushed, expected trigger_hit}
    localparam logic [23:0] VEC [8] = '{
        24'h03_01_01, 24'h43_03_00, 24'h43_04_01, 24'h83_07_00,
        24'h8B_08_01, 24'hC3_0D_00, 24'hC3_0E_01, 24'hF7_10_01
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b; tick(); rx_valid = 1'b0;
    endtask

    task automatic push_break();
        rx_break = 1'b1; tick(); rx_break = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        rbr_rd = 1'b1; d = rd_data; tick(); rbr_rd = 1'b0;
    endtask

    task automatic lsr_read();
        lsr_rd = 1'b1; tick(); lsr_rd = 1'b0;
    endtask

    task automatic fcr_write(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v; tick(); fcr_wr = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; rx_valid = 0; rx_break = 0; rbr_rd = 0; lsr_rd = 0; fcr_wr = 0;
        rx_data = 0; fcr_wdata = 0; divisor = 16'd1; frame_fmt = 4'h0;
        tick(); tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 level", 32'(fifo_level), 0);
        check("R1 flags", {data_ready, overrun, break_flag, timeout_pending, tx_flush}, 0);
        check("R1 fcr", 32'(fcr_value), 0);
        check("R1 rd_data", 32'(rd_data), 0);

        // R2 trigger table
        for (int i = 0; i < 8; i++) begin
            fcr_write(VEC[i][23:16] | 8'h02);
            for (int k = 0; k < int'(VEC[i][15:8]); k++) push(8'(k));
            check("R2 fcr_value", 32'(fcr_value), 32'(VEC[i][23:16] & 8'hC9));
            check("R2 level", 32'(fifo_level), 32'(VEC[i][15:8]));
            check("R2 trigger_hit", 32'(trigger_hit), 32'(VEC[i][0]));
        end

        // R4 ordering and empty read
        fcr_write(8'h03);
        push(8'hA5); push(8'h3C); push(8'h7E);
        rd(d); check("R4 first", 32'(d), 32'hA5);
        rd(d); check("R4 second", 32'(d), 32'h3C);
        check("R4 dr kept", 32'(data_ready), 1);
        rd(d); check("R4 third", 32'(d), 32'h7E);
        check("R4 dr cleared", 32'(data_ready), 0);
        rd(d); check("R4 empty read", 32'(d), 0);

        // R5 overflow
        fcr_write(8'h03);
        for (int k = 0; k < 17; k++) push(8'(k));
        check("R5 level", 32'(fifo_level), 16);
        check("R5 overrun", 32'(overrun), 1);
        rd(d); check("R5 oldest", 32'(d), 0);
        lsr_read();
        check("R8 oe cleared", 32'(overrun), 0);
        check("R8 dr kept", 32'(data_ready), 1);
        for (int k = 0; k < 15; k++) rd(d);
        check("R5 last kept byte", 32'(d), 15);
        check("R5 drained", 32'(fifo_level), 0);

        // R7 / R8 break
        fcr_write(8'h03);
        push_break();
        check("R7 level", 32'(fifo_level), 1);
        check("R7 flags", {break_flag, data_ready}, 2'b11);
        lsr_read();
        check("R8 bi cleared", {break_flag, data_ready}, 2'b01);
        rd(d); check("R7 zero byte", 32'(d), 0);
        push_break();
        rd(d);
        check("R4 read clears bi/dr", {break_flag, data_ready}, 0);

        // R10 enable toggle and transmit clear
        push(8'h11);
        fcr_write(8'h00);
        check("R10 tx_flush on toggle", 32'(tx_flush), 1);
        check("R10 rx flushed", 32'(fifo_level), 0);
        check("R10 dr cleared", 32'(data_ready), 0);
        tick();
        check("R10 tx_flush one cycle", 32'(tx_flush), 0);
        fcr_write(8'h04);
        check("R10 tx_flush on bit2", 32'(tx_flush), 1);
        check("R10 fcr stays", 32'(fcr_value), 0);

        // R6 / R3 single-register mode
        push(8'h11);
        check("R3 trigger follows dr", {data_ready, trigger_hit, overrun}, 3'b110);
        push(8'h22);
        check("R6 overrun", 32'(overrun), 1);
        repeat (500) tick();
        check("R11 no timeout in single mode", 32'(timeout_pending), 0);
        rd(d); check("R6 overwritten", 32'(d), 32'h22);
        check("R3 trigger drops", {data_ready, trigger_hit}, 0);
        lsr_read();

        // R11 timeout: divisor 1, 7-bit frame -> 4*112 = 448 cycles
        fcr_write(8'h03);
        push(8'h55);
        repeat (447) tick();
        check("R11 not yet", 32'(timeout_pending), 0);
        tick();
        check("R11 pending", 32'(timeout_pending), 1);
        rd(d);
        check("R11 read clears", 32'(timeout_pending), 0);
        push(8'h01);
        repeat (300) tick();
        push(8'h02);
        repeat (447) tick();
        check("R11 restart on arrival", 32'(timeout_pending), 0);
        tick();
        check("R11 pending after restart", 32'(timeout_pending), 1);
        fcr_write(8'h03);
        check("R9 clear", {timeout_pending, data_ready, 3'(fifo_level)}, 0);

        // R11 divisor 0 -> 1, 12-bit frame -> 4*192 = 768 cycles
        divisor = 16'd0; frame_fmt = 4'hF;
        push(8'h09);
        repeat (767) tick();
        check("R11 long frame not yet", 32'(timeout_pending), 0);
        tick();
        check("R11 long frame pending", 32'(timeout_pending), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule